// File: doc/BRIEF.md
# Serial-to-Parallel Word Converter with Output Hold Register

The block takes a serial bit stream, one bit per rising edge of the bit clock, and turns it into parallel words of `WORD_W` bits, eight by default. The serial input feeds a shift register. A separate hold register presents each finished word and keeps it unchanged while the next word shifts in behind it. Alongside the word, the block produces a word clock at one eighth of the bit rate with a 50 % duty cycle. A 10 Mbit/s stream therefore yields 1.25 Mwords/s.

All flops run on the bit clock. A modulo-`WORD_W` counter replaces a ripple divider. When the counter wraps, it gives a one-cycle load strobe to the hold register and sets the exported word clock. The word clock rises on the same edge that updates the word. A downstream consumer can therefore take the word on any word clock edge: the data stays stable for a whole word period.

Top module: `s2p_conv`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, the shift register, the hold register, the word counter and the word clock are cleared. Directly after reset `word_o` reads all zeros and `wclk_o` reads 0.
- R2: `sdin_i` is sampled on every rising edge of `clk_i`. Each new sample enters bit 0 and the older bits move one place toward bit `WORD_W-1`. In a presented word, the earliest of the eight bits is in bit 7 (D7) and the latest is in bit 0 (D0).
- R3: The hold register loads exactly once every `WORD_W` rising edges. The word it loads includes the bit sampled on that same edge. After reset, the first word appears on the eighth sampled edge and not earlier.
- R4: Between two loads, `word_o` stays constant for the full word period, even though the shift register changes on every edge.
- R5: `wclk_o` rises on the edge that loads a new word. It then stays high for `WORD_W/2` bit periods and low for `WORD_W/2` bit periods. From reset until the first load it is low.
- R6: A reset asserted in the middle of a word drops the partial word. Word alignment restarts, so the next word is made of the eight bits sampled after reset is released.
- R7: Words follow each other with no gap. Every bit of a continuous stream lands in exactly one presented word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock; all sampling on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| sdin_i | input | 1 | Serial data input |
| word_o | output | WORD_W | Held parallel word, earliest bit in the MSB |
| wclk_o | output | 1 | Word clock, bit clock divided by WORD_W |

## Verification
On the last bit of each word, the block does two things on one edge. It shifts in the final serial bit, and it loads the hold register with a word that must already contain that bit. The bench streams words back to back without idle cycles, so every load edge also samples a fresh bit. After each eighth bit, the presented word is compared against the pattern that was sent, and the word clock is checked to be high. If the load used the shift register contents from before that edge, the word would come out one bit late and the check would fail. Mid-word samples of the output confirm that the hold register did not follow the shift register in between.

// File: rtl/s2p_pkg.sv
package s2p_pkg;
    // Default word width (bits gathered per parallel word)
    localparam int DEF_WORD_W = 8;

    // Width of a counter able to index positions 0..w-1
    function automatic int cnt_width(input int w);
        return (w > 2) ? $clog2(w) : 1;
    endfunction
endpackage

// File: rtl/s2p_shifter.sv
module s2p_shifter #(
    parameter int W = s2p_pkg::DEF_WORD_W
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         bit_i,
    output logic [W-1:0] next_o
);
    typedef struct packed {
        logic [W-1:0] sr;
    } shf_t;

    shf_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        // newest sample enters bit 0, older bits move toward the MSB
        st_d.sr = {st_q.sr[W-2:0], bit_i};
        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    // Content the register takes at this edge (includes the current bit)
    assign next_o = st_d.sr;
endmodule

// File: rtl/s2p_pacer.sv
module s2p_pacer #(
    parameter int W = s2p_pkg::DEF_WORD_W
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic load_o,
    output logic wclk_o
);
    localparam int            CW      = s2p_pkg::cnt_width(W);
    localparam logic [CW-1:0] LAST    = CW'(W - 1);
    localparam logic [CW-1:0] HALF_M1 = CW'(W / 2 - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          wclk;
    } pace_t;

    pace_t st_d, st_q;
    logic  wrap;

    assign wrap = (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (wrap) begin
            st_d.cnt  = '0;
            st_d.wclk = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == HALF_M1) begin
                st_d.wclk = 1'b0;
            end
        end
        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign load_o = wrap;
    assign wclk_o = st_q.wclk;
endmodule

// File: rtl/s2p_holdreg.sv
module s2p_holdreg #(
    parameter int W = s2p_pkg::DEF_WORD_W
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         load_i,
    input  logic [W-1:0] word_i,
    output logic [W-1:0] word_o
);
    typedef struct packed {
        logic [W-1:0] word;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.word = word_i;
        end
        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign word_o = st_q.word;
endmodule

// File: rtl/s2p_conv.sv
module s2p_conv #(
    parameter int WORD_W = s2p_pkg::DEF_WORD_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              sdin_i,
    output logic [WORD_W-1:0] word_o,
    output logic              wclk_o
);
    logic [WORD_W-1:0] shift_next_w;
    logic              load_w;

    s2p_shifter #(.W(WORD_W)) u_shift (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .bit_i  (sdin_i),
        .next_o (shift_next_w)
    );

    s2p_pacer #(.W(WORD_W)) u_pace (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_o (load_w),
        .wclk_o (wclk_o)
    );

    s2p_holdreg #(.W(WORD_W)) u_hold (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (load_w),
        .word_i (shift_next_w),
        .word_o (word_o)
    );
endmodule

// File: rtl/s2p_conv_chk.sv
module s2p_conv_chk #(
    parameter int W = s2p_pkg::DEF_WORD_W
) (
    input logic         clk_i,
    input logic         rst_i,
    input logic         sdin_i,
    input logic [W-1:0] word_o,
    input logic         wclk_o,
    input logic         load_i
);
    localparam int            CW   = s2p_pkg::cnt_width(W) + 1;
    localparam logic [CW-1:0] HALF = CW'(W / 2);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] run_q;
    logic [CW-1:0] since_q;
    logic          prev_q;
    logic          armed_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            run_q   <= CW'(1);
            since_q <= '0;
            prev_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (wclk_o != prev_q) begin
                run_q <= CW'(1);
                if (wclk_o) armed_q <= 1'b1;
            end else begin
                run_q <= run_q + 1'b1;
            end
            prev_q  <= wclk_o;
            since_q <= load_i ? '0 : since_q + 1'b1;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (word_o == '0 && !wclk_o));

    // R2
    lsb_latest_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> word_o[0] == $past(sdin_i));

    // R3
    load_period_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i == (since_q == LAST));

    // R4
    hold_stable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$rose(wclk_o) |-> $stable(word_o));

    // R5
    rise_on_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> $rose(wclk_o));

    // R5
    duty_half_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed_q && (wclk_o != prev_q)) |-> run_q == HALF);
endmodule

bind s2p_conv s2p_conv_chk #(.W(WORD_W)) u_chk (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .sdin_i (sdin_i),
    .word_o (word_o),
    .wclk_o (wclk_o),
    .load_i (load_w)
);

// File: tb/sim_s2p_conv.sv
`timescale 1ns/1ps
module sim_s2p_conv;
    localparam int W   = 8;
    localparam int NV  = 8;
    // {stimulus sent first-bit-first from bit 7, expected word}
    localparam logic [2*W-1:0] VEC [NV] = '{
        {8'b01001001, 8'b01001001},
        {8'b10100101, 8'b10100101},
        {8'b00100000, 8'b00100000},
        {8'b11111111, 8'b11111111},
        {8'b01111111, 8'b01111111},
        {8'b00000000, 8'b00000000},
        {8'b10010101, 8'b10010101},
        {8'b00010101, 8'b00010101}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sdin = 1'b0;
    logic [W-1:0] word;
    logic         wclk;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    s2p_conv #(.WORD_W(W)) u0 (
        .clk_i  (clk),
        .rst_i  (rst),
        .sdin_i (sdin),
        .word_o (word),
        .wclk_o (wclk)
    );

    task automatic check(input logic ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Called at a falling edge; drives a bit, returns at the next falling edge
    task automatic push(input logic b);
        sdin = b;
        @(negedge clk);
    endtask

    task automatic do_reset(input int cycles);
        rst = 1'b1;
        repeat (cycles) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [W-1:0] prev;
        logic [W-1:0] pat;

        // R1: reset state with the serial input held high
        sdin = 1'b1;
        @(negedge clk);
        do_reset(3);
        check(word == '0, "R1 word", word, '0);
        check(wclk == 1'b0, "R1 wclk", {7'd0, wclk}, 8'd0);

        // R3: no word before the eighth bit
        for (int k = 0; k < W - 1; k++) push(1'b1);
        check(word == '0, "R3 early", word, '0);
        check(wclk == 1'b0, "R5 low before first load", {7'd0, wclk}, 8'd0);
        push(1'b1);
        check(word == 8'hFF, "R3 first word", word, 8'hFF);

        // R2, R4, R5, R7: back-to-back stream from the table
        prev = 8'hFF;
        for (int i = 0; i < NV; i++) begin
            pat = VEC[i][2*W-1:W];
            for (int k = W - 1; k >= 0; k--) begin
                push(pat[k]);
                if (k == 4) check(word == prev, "R4 hold mid-word", word, prev);
                if (k == 1) check(wclk == 1'b0, "R5 low late in word", {7'd0, wclk}, 8'd0);
            end
            check(word == VEC[i][W-1:0], "R2 R7 word order", word, VEC[i][W-1:0]);
            check(wclk == 1'b1, "R5 high at load", {7'd0, wclk}, 8'd1);
            prev = VEC[i][W-1:0];
        end

        // R5: word clock pattern across one word period, starting at a load
        begin
            logic [W-1:0] seen;
            seen = '0;
            for (int k = W - 1; k >= 0; k--) begin
                seen[k] = wclk;
                push(1'b0);
            end
            check(seen == 8'b11110000, "R5 duty", seen, 8'b11110000);
        end

        // R6: reset mid-word drops the partial word and realigns
        push(1'b1); push(1'b1); push(1'b1);
        do_reset(2);
        check(word == '0, "R6 cleared", word, '0);
        check(wclk == 1'b0, "R6 wclk cleared", {7'd0, wclk}, 8'd0);
        pat = 8'b11000011;
        for (int k = W - 1; k >= 1; k--) push(pat[k]);
        check(word == '0, "R6 no early word", word, '0);
        push(pat[0]);
        check(word == pat, "R6 realigned word", word, pat);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule